// File: doc/BRIEF.md
# RC Servo Pulse to PWM Bridge

The block listens to a radio-control style command pulse on a single pin and turns it into a proportional PWM output. It synchronizes the pin, times one high pulse in clock cycles, and clamps that time to a window of 920 µs to 2120 µs. It then maps the window linearly onto an 8-bit duty value. A phase-correct PWM generator with a top count of 255 turns that duty into the output waveform. A width of 1520 µs is the neutral point and lands at mid-scale.

After a pulse has been timed, the block ignores the pin until the new duty has been computed and loaded. It then listens again, but only for a fresh rising transition. If the pin is already high at that moment, the block waits for the next pulse. The window limits are derived from the clock frequency. A prescale option divides the width count by 2^PRE_LOG2, which is 16 in the slow variant.

Top module: `rc_pwm_bridge`

## Requirements
- R1: While reset is asserted and right after it, pwm_o is 0, duty_o is 0 and capt_o is 0.
- R2: The pin passes through two flip-flops. A pulse measures as the number of rising clock edges that sample the pin high. The new duty and the strobe appear on the fourth rising edge that samples the pin low, counting the first such edge as one.
- R3: A measured width at or below MIN_CNT = floor(920 µs × CLK_HZ / 2^PRE_LOG2) gives duty 0.
- R4: A measured width at or above MAX_CNT = floor(2120 µs × CLK_HZ / 2^PRE_LOG2) gives duty 255.
- R5: A width W inside the window gives duty floor((W − MIN_CNT) × 255 / (MAX_CNT − MIN_CNT)), so the neutral width gives 127.
- R6: Between a capture and the cycle after its duty is loaded, pin transitions are ignored. Re-arming needs a new low-to-high transition, and a high-to-low transition with no timed rise before it has no effect.
- R7: The width counter saturates instead of wrapping, so a pulse longer than the counter range gives duty 255.
- R8: The PWM counts 0 up to 255 and back down, with a period of 510 clocks. With a steady duty D, pwm_o is high for exactly 2×D clocks of every period: 0 is always low and 255 is always high.
- R9: A new duty takes effect in the PWM only when the counter reaches 255, so no period mixes two duty values.
- R10: With PRE_LOG2 = 4, the width is the pulse's clock count divided by 16 and rounded down, and R3 to R5 then apply to that width.
- R11: capt_o is high for exactly one clock, in the cycle in which duty_o first shows the new value, and duty_o changes in no other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Raw command pulse pin, asynchronous |
| pwm_o | output | 1 | Phase-correct PWM output, non-inverting |
| duty_o | output | 8 | Most recently loaded duty value |
| capt_o | output | 1 | One-clock strobe marking a new duty value |

## Verification
The hardest case to reach is the lockout window. A second pulse has to start while the first is still being scaled, and then end once the block is listening again. The stimulus ends one pulse and raises the pin again after a single low clock. The block must then ignore both the late rise and the orphan fall, and keep the first pulse's duty. Counter saturation is reached with a pulse longer than the width counter's range, which a wrapping counter would decode as near zero. The prescaled variant runs on the same pin with pulses sixteen times longer.

// File: rtl/rcpwm_pkg.sv
package rcpwm_pkg;

    localparam int DUTY_W = 8;
    localparam logic [DUTY_W-1:0] PWM_TOP = '1;

    typedef enum logic [1:0] {
        CAP_ARMED  = 2'd0,
        CAP_TIMING = 2'd1,
        CAP_LOCKED = 2'd2
    } cap_state_e;

    // Clock count for a pulse of 'us' microseconds after prescaling by 2^pre
    function automatic longint unsigned win_count(longint unsigned us,
                                                  longint unsigned hz,
                                                  int pre);
        return (us * hz) / (64'd1_000_000 << pre);
    endfunction

endpackage

// File: rtl/rcpwm_capture.sv
module rcpwm_capture
    import rcpwm_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int PRE_LOG2 = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             rearm_i,
    output logic             stb_o,
    output logic [CNT_W-1:0] width_o
);
    localparam int EL_W = CNT_W + PRE_LOG2;

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             prev;
        cap_state_e       st;
        logic [EL_W-1:0]  el;
        logic [CNT_W-1:0] width;
        logic             stb;
    } cap_t;

    cap_t q, d;
    logic rise, fall;

    always_comb begin
        d      = q;
        d.s1   = pin_i;
        d.s2   = q.s1;
        d.prev = q.s2;
        d.stb  = 1'b0;
        rise   = q.s2 & ~q.prev;
        fall   = ~q.s2 & q.prev;
        unique case (q.st)
            CAP_ARMED: begin
                if (rise) begin
                    d.st = CAP_TIMING;
                    d.el = EL_W'(1);
                end
            end
            CAP_TIMING: begin
                if (fall) begin
                    d.st    = CAP_LOCKED;
                    d.width = CNT_W'(q.el >> PRE_LOG2);
                    d.stb   = 1'b1;
                end else if (q.el != '1) begin
                    d.el = q.el + 1'b1;
                end
            end
            CAP_LOCKED: begin
                if (rearm_i) d.st = CAP_ARMED;
            end
            default: d.st = CAP_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stb_o   = q.stb;
    assign width_o = q.width;

endmodule

// File: rtl/rcpwm_scale.sv
module rcpwm_scale
    import rcpwm_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int MIN_CNT = 92,
    parameter int MAX_CNT = 212
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic [CNT_W-1:0]  width_i,
    output logic [DUTY_W-1:0] duty_o,
    output logic              load_o
);
    localparam int SPAN   = MAX_CNT - MIN_CNT;
    localparam int PROD_W = CNT_W + DUTY_W;

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic              load;
    } sc_t;

    sc_t q, d;
    logic [CNT_W-1:0]  clamped;
    logic [PROD_W-1:0] prod;

    always_comb begin
        d = q;
        if (width_i < CNT_W'(MIN_CNT))      clamped = CNT_W'(MIN_CNT);
        else if (width_i > CNT_W'(MAX_CNT)) clamped = CNT_W'(MAX_CNT);
        else                                clamped = width_i;
        prod   = PROD_W'(clamped - CNT_W'(MIN_CNT)) * PROD_W'(PWM_TOP);
        d.load = stb_i;
        if (stb_i) d.duty = DUTY_W'(prod / PROD_W'(SPAN));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign duty_o = q.duty;
    assign load_o = q.load;

endmodule

// File: rtl/rcpwm_pwm.sv
module rcpwm_pwm
    import rcpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o
);
    typedef struct packed {
        logic [DUTY_W-1:0] cnt;
        logic              up;
        logic [DUTY_W-1:0] ocr;
        logic              out;
    } pw_t;

    pw_t q, d;

    always_comb begin
        d = q;
        if (q.up) begin
            if (q.cnt == PWM_TOP) begin
                d.cnt = PWM_TOP - 1'b1;
                d.up  = 1'b0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            if (q.cnt == '0) begin
                d.cnt = DUTY_W'(1);
                d.up  = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
        // compare value only reloads at the turning point
        if (q.cnt == PWM_TOP) d.ocr = duty_i;
        if (q.ocr == '0)          d.out = 1'b0;
        else if (q.ocr == PWM_TOP) d.out = 1'b1;
        else if (q.up)            d.out = (q.cnt < q.ocr);
        else                      d.out = (q.cnt <= q.ocr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pwm_o = q.out;

endmodule

// File: rtl/rc_pwm_bridge.sv
module rc_pwm_bridge
    import rcpwm_pkg::*;
#(
    parameter longint unsigned CLK_HZ   = 1_200_000,
    parameter int              MIN_US   = 920,
    parameter int              MAX_US   = 2120,
    parameter int              PRE_LOG2 = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_i,
    output logic              pwm_o,
    output logic [DUTY_W-1:0] duty_o,
    output logic              capt_o
);
    localparam int MIN_CNT = int'(win_count(longint'(MIN_US), CLK_HZ, PRE_LOG2));
    localparam int MAX_CNT = int'(win_count(longint'(MAX_US), CLK_HZ, PRE_LOG2));
    localparam int CNT_W   = $clog2(MAX_CNT + 2) + 1;

    logic             cap_stb;
    logic [CNT_W-1:0] cap_width;
    logic             load;
    logic [DUTY_W-1:0] duty;

    rcpwm_capture #(.CNT_W(CNT_W), .PRE_LOG2(PRE_LOG2)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pulse_i),
        .rearm_i (load),
        .stb_o   (cap_stb),
        .width_o (cap_width)
    );

    rcpwm_scale #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT), .MAX_CNT(MAX_CNT)) u_scale (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (cap_stb),
        .width_i (cap_width),
        .duty_o  (duty),
        .load_o  (load)
    );

    rcpwm_pwm u_pwm (
        .clk    (clk),
        .rst_n  (rst_n),
        .duty_i (duty),
        .pwm_o  (pwm_o)
    );

    assign duty_o = duty;
    assign capt_o = load;

endmodule

// File: rtl/rc_pwm_bridge_chk.sv
module rc_pwm_bridge_chk #(
    parameter int CNT_W   = 9,
    parameter int MIN_CNT = 92,
    parameter int MAX_CNT = 212
) (
    input logic             clk,
    input logic             rst_n,
    input logic             capt_o,
    input logic [7:0]       duty_o,
    input logic             cap_stb,
    input logic [CNT_W-1:0] cap_width
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        capt_o |=> !capt_o); // R11

    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capt_o |-> duty_o == $past(duty_o)); // R11

    AST_LOAD_FOLLOWS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> capt_o); // R2

    AST_NO_LOAD_WITHOUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        capt_o |-> $past(cap_stb)); // R6

    AST_LOW_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_stb && int'(cap_width) <= MIN_CNT) |=> duty_o == 8'd0); // R3

    AST_HIGH_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_stb && int'(cap_width) >= MAX_CNT) |=> duty_o == 8'd255); // R4
endmodule

bind rc_pwm_bridge rc_pwm_bridge_chk #(
    .CNT_W   (CNT_W),
    .MIN_CNT (MIN_CNT),
    .MAX_CNT (MAX_CNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .capt_o    (capt_o),
    .duty_o    (duty_o),
    .cap_stb   (cap_stb),
    .cap_width (cap_width)
);

// File: tb/test_rc_pwm_bridge.sv
module rc_ref_model #(
    parameter longint CLK_HZ   = 100_000,
    parameter int     PRE_LOG2 = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic exp_pwm,
    output int   exp_duty,
    output logic exp_capt
);
    localparam longint DIVISOR = 64'd1_000_000 * (longint'(1) << PRE_LOG2);
    localparam int WMIN = int'((920 * CLK_HZ) / DIVISOR);
    localparam int WMAX = int'((2120 * CLK_HZ) / DIVISOR);

    int phase, ocr, state, el, lk, pend;
    bit hist[$];
    bit s2, pv, nxt;

    function automatic int to_duty(int w);
        int c;
        c = w;
        if (c < WMIN) c = WMIN;
        if (c > WMAX) c = WMAX;
        return (c - WMIN) * 255 / (WMAX - WMIN);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0; ocr = 0; state = 0; el = 0; lk = 0; pend = 0;
            exp_pwm = 0; exp_duty = 0; exp_capt = 0;
            hist = '{0, 0, 0, 0};
        end else begin
            // PWM: 510-step period; high window centred on the bottom
            nxt = (phase < ocr) || (phase >= 510 - ocr);
            if (phase == 255) ocr = exp_duty;
            phase = (phase + 1) % 510;
            exp_pwm = nxt;
            // synchronised pin history
            hist.push_back(pin);
            if (hist.size() > 6) void'(hist.pop_front());
            s2 = hist[hist.size() - 3];
            pv = hist[hist.size() - 4];
            exp_capt = 0;
            if (state == 2) begin
                if (lk == 2) begin
                    exp_duty = pend; exp_capt = 1; lk = 1;
                end else begin
                    state = 0;
                end
            end else if (state == 0) begin
                if (s2 && !pv) begin state = 1; el = 1; end
            end else begin
                if (!s2 && pv) begin
                    state = 2; lk = 2; pend = to_duty(el >> PRE_LOG2);
                end else begin
                    el = el + 1;
                end
            end
        end
    end
endmodule

module test_rc_pwm_bridge;
    logic clk = 0;
    logic rst_n = 0;
    logic pin = 0;
    always #5 clk = ~clk;

    logic       pwm_a, capt_a, pwm_b, capt_b;
    logic [7:0] duty_a, duty_b;
    logic       e_pwm_a, e_capt_a, e_pwm_b, e_capt_b;
    int         e_duty_a, e_duty_b;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    rc_pwm_bridge #(.CLK_HZ(100_000), .PRE_LOG2(0)) i_rc_pwm_bridge (
        .clk(clk), .rst_n(rst_n), .pulse_i(pin),
        .pwm_o(pwm_a), .duty_o(duty_a), .capt_o(capt_a));

    rc_pwm_bridge #(.CLK_HZ(1_600_000), .PRE_LOG2(4)) i_rc_pwm_bridge_div16 (
        .clk(clk), .rst_n(rst_n), .pulse_i(pin),
        .pwm_o(pwm_b), .duty_o(duty_b), .capt_o(capt_b));

    rc_ref_model #(.CLK_HZ(100_000), .PRE_LOG2(0)) u_ref_a (
        .clk(clk), .rst_n(rst_n), .pin(pin),
        .exp_pwm(e_pwm_a), .exp_duty(e_duty_a), .exp_capt(e_capt_a));

    rc_ref_model #(.CLK_HZ(1_600_000), .PRE_LOG2(4)) u_ref_b (
        .clk(clk), .rst_n(rst_n), .pin(pin),
        .exp_pwm(e_pwm_b), .exp_duty(e_duty_b), .exp_capt(e_capt_b));

    task automatic check(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // every-cycle comparison against the behavioural model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 R9 pwm", int'(pwm_a), int'(e_pwm_a));
            check("R2 R5 duty", int'(duty_a), e_duty_a);
            check("R11 capt", int'(capt_a), int'(e_capt_a));
            check("R10 pwm div16", int'(pwm_b), int'(e_pwm_b));
            check("R10 duty div16", int'(duty_b), e_duty_b);
            check("R10 capt div16", int'(capt_b), int'(e_capt_b));
        end
    end

    task automatic pulse(int hi, int lo);
        pin = 1;
        repeat (hi) @(negedge clk);
        pin = 0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic high_count(string tag, int exp);
        int n;
        n = 0;
        repeat (520) @(negedge clk);
        repeat (510) begin
            @(negedge clk);
            n += int'(pwm_a);
        end
        check(tag, n, exp);
    endtask

    initial begin
        int k;
        repeat (5) @(negedge clk);
        check("R1 pwm", int'(pwm_a), 0);
        check("R1 duty", int'(duty_a), 0);
        check("R1 capt", int'(capt_a), 0);
        check("R1 div16 duty", int'(duty_b), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 pwm after release", int'(pwm_a), 0);

        // neutral pulse with latency measurement
        pin = 1;
        repeat (152) @(negedge clk);
        pin = 0;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!capt_a && k < 20);
        check("R2 latency", k, 4);
        check("R5 neutral", int'(duty_a), 127);
        @(negedge clk);
        check("R11 strobe one clock", int'(capt_a), 0);
        repeat (20) @(negedge clk);
        high_count("R8 high clocks at 127", 254);

        pulse(212, 30); check("R4 at max", int'(duty_a), 255);
        high_count("R8 always high at 255", 510);
        pulse(50, 30);  check("R3 below min", int'(duty_a), 0);
        pulse(300, 30); check("R4 above max", int'(duty_a), 255);
        pulse(92, 30);  check("R3 at min", int'(duty_a), 0);
        high_count("R8 always low at 0", 0);

        pulse(130, 30); check("R5 mid value", int'(duty_a), 80);
        pulse(153, 30); check("R5 above neutral", int'(duty_a), 129);
        high_count("R8 high clocks at 129", 258);

        pulse(600, 30); check("R7 saturation", int'(duty_a), 255);

        // second pulse starts inside the lockout window
        pulse(152, 1);
        pulse(100, 40);
        check("R6 lockout keeps duty", int'(duty_a), 127);

        pulse(2432, 40);
        check("R10 div16 neutral", int'(duty_b), 127);
        check("R7 long pulse fast", int'(duty_a), 255);
        pulse(2080, 40); check("R10 div16 mid", int'(duty_b), 80);
        pulse(3400, 40); check("R10 div16 max", int'(duty_b), 255);
        pulse(1487, 40); check("R10 div16 at min", int'(duty_b), 0);
        pulse(1500, 40); check("R10 div16 floor", int'(duty_b), 2);

        repeat (600) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule